// File: doc/BRIEF.md
# PCIe Interrupt Aggregator

This block collects interrupt events from a PCIe root port and folds them into a single interrupt line for the host. The events are an MSI arrival with its vector and data byte, legacy INTx assert and deassert messages, a power-management event message, a power-state change and a flush notice. Each event sets a bit in a write-one-to-clear status register, and each status register has a mask register beside it.

The levels are chained. An unmasked MSI vector keeps the MSI-pending bit of the first-level register set. Any active bit in the first or second level keeps the core bit of the host-level register set. A small state machine with the states IRQ_IDLE and IRQ_RAISED drives the output line from the host level. It moves from IRQ_IDLE to IRQ_RAISED on the clock after an unmasked implemented host bit is seen set. It moves back to IRQ_IDLE on the clock after no such bit remains.

Software reaches every register through a simple word-addressed register bus. Writes take effect on the clock edge. Reads return data combinationally. An interrupt service routine clears the levels from the bottom up: MSI vectors first, then the first level, then the host level.

Top module: `irqagg_top`

## Requirements
- R1: After reset every status register, the payload register and both MSI address registers read 0. The first-level mask reads 0x07FFFFFF, the second-level mask reads 0x00000FF0, the host mask reads 0x00FFF0FB and the MSI mask reads 0xFFFFFFFF. The output irq_o is low.
- R2: An MSI arrival with vector v sets bit v of the MSI status register. The same arrival loads its data byte into the low 8 bits of the payload register, whether or not vector v is masked.
- R3: First-level bit 24 (MSI pending) is set on each clock while the MSI status has a set bit whose MSI mask bit is 0. A masked vector does not set it. Masking a status bit does not clear it.
- R4: INTx n assert sets first-level bit 16+n and second-level bit 8+n. INTx n deassert sets first-level bit 20+n. A PME message sets first-level bit 7. A power-state change sets second-level bit 4 and a flush sets second-level bit 5.
- R5: Host status bit 16 is set on each clock while the first level (bits 26:0) or the second level (bits 11:4) holds a set bit whose mask bit is 0.
- R6: irq_o goes high on the clock after (host status AND NOT host mask AND 0x00FFF0FB) becomes nonzero. It goes low on the clock after that value becomes zero.
- R7: Writing to a status register clears exactly the bits written as 1. Bits written as 0 are unchanged, and writing all ones clears the whole register.
- R8: When a status bit is set by an event and cleared by a write in the same cycle, the bit ends up set.
- R9: Mask and MSI address registers read back what was written. A mask keeps only its level's valid bits. The payload register ignores writes.
- R10: The word addresses are: 0 first-level status, 1 first-level mask, 2 second-level status, 3 second-level mask, 4 host status, 5 host mask, 6 MSI status, 7 MSI mask, 8 payload, 9 MSI address low, 10 MSI address high. Any other address reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| msi_valid | input | 1 | MSI arrival pulse |
| msi_vec | input | 5 | MSI vector number |
| msi_data | input | 8 | MSI data byte |
| intx_assert | input | 4 | INTx assert pulses, one per line |
| intx_deassert | input | 4 | INTx deassert pulses, one per line |
| pme_evt | input | 1 | PME message pulse |
| pwr_chg_evt | input | 1 | Power-state change pulse |
| flush_evt | input | 1 | Flush pulse |
| irq_o | output | 1 | Summary interrupt line |

## Verification
The cascade is exercised with two MSI arrivals, one to a masked vector and one to an unmasked vector. This separates status capture from the propagation of the pending bit. INTx assert and deassert on the same line, a PME message, and power and flush events show that each source lands on its own bit at the correct level. Masking is applied in turn at the first level, the second level and the host level; the line falls each time while the status bits are kept. Simultaneous event and clear cycles, a partial clear and a mid-run reset cover the ordering corner cases.

// File: rtl/irqagg_pkg.sv
package irqagg_pkg;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 4;
    localparam int NUM_INTX   = 4;
    localparam int MSI_VECS   = 32;
    localparam int PAYLOAD_W  = 8;

    localparam logic [DATA_W-1:0] L1_VALID  = 32'h07FF_FFFF;
    localparam logic [DATA_W-1:0] L2_VALID  = 32'h0000_0FF0;
    localparam logic [DATA_W-1:0] HOST_IMPL = 32'h00FF_F0FB;

    localparam int L1_PME_BIT   = 7;
    localparam int L1_ASRT_BASE = 16;
    localparam int L1_DEAS_BASE = 20;
    localparam int L1_MSI_BIT   = 24;
    localparam int L2_PWR_BIT   = 4;
    localparam int L2_FLUSH_BIT = 5;
    localparam int L2_ASRT_BASE = 8;
    localparam int HOST_CORE    = 16;

    typedef enum logic [ADDR_W-1:0] {
        A_L1_STAT     = 4'd0,
        A_L1_MASK     = 4'd1,
        A_L2_STAT     = 4'd2,
        A_L2_MASK     = 4'd3,
        A_HOST_STAT   = 4'd4,
        A_HOST_MASK   = 4'd5,
        A_MSI_STAT    = 4'd6,
        A_MSI_MASK    = 4'd7,
        A_MSI_DATA    = 4'd8,
        A_MSI_ADDR_LO = 4'd9,
        A_MSI_ADDR_HI = 4'd10
    } reg_addr_e;

    typedef enum logic {
        IRQ_IDLE   = 1'b0,
        IRQ_RAISED = 1'b1
    } irq_state_e;
endpackage

// File: rtl/irqagg_w1c_reg.sv
module irqagg_w1c_reg #(
    parameter int               W     = 32,
    parameter logic [W-1:0]     VALID = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_we,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_eff;

    always_comb clr_eff = clr_we ? clr_i : '0;

    // Event sets take priority over a same-cycle clear.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= ((q & ~clr_eff) | set_i) & VALID;
    end
endmodule

// File: rtl/irqagg_msi_bank.sv
module irqagg_msi_bank #(
    parameter int VECS      = 32,
    parameter int VEC_W     = 5,
    parameter int PAYLOAD_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 msi_valid,
    input  logic [VEC_W-1:0]     msi_vec,
    input  logic [PAYLOAD_W-1:0] msi_data,
    input  logic                 stat_we,
    input  logic                 mask_we,
    input  logic [VECS-1:0]      wdata,
    output logic [VECS-1:0]      stat_q,
    output logic [VECS-1:0]      mask_q,
    output logic [PAYLOAD_W-1:0] payload_q,
    output logic                 active
);
    logic [VECS-1:0] vec_set;

    always_comb begin
        vec_set = '0;
        if (msi_valid) vec_set[msi_vec] = 1'b1;
    end

    irqagg_w1c_reg #(.W(VECS), .VALID({VECS{1'b1}})) u_stat (
        .clk(clk), .rst_n(rst_n), .set_i(vec_set),
        .clr_we(stat_we), .clr_i(wdata), .q(stat_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q    <= '1;
            payload_q <= '0;
        end else begin
            if (mask_we)   mask_q    <= wdata;
            if (msi_valid) payload_q <= msi_data;
        end
    end

    always_comb active = |(stat_q & ~mask_q);
endmodule

// File: rtl/irqagg_irq_fsm.sv
module irqagg_irq_fsm
    import irqagg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic core_act,
    output logic irq_o
);
    irq_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IRQ_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE:   if (core_act)  state_d = IRQ_RAISED;
            IRQ_RAISED: if (!core_act) state_d = IRQ_IDLE;
            default:    state_d = IRQ_IDLE;
        endcase
    end

    always_comb irq_o = (state_q == IRQ_RAISED);
endmodule

// File: rtl/irqagg_top.sv
module irqagg_top
    import irqagg_pkg::*;
#(
    parameter int N_INTX = NUM_INTX,
    parameter int N_VECS = MSI_VECS,
    parameter int VEC_W  = $clog2(MSI_VECS),
    parameter int PLD_W  = PAYLOAD_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              msi_valid,
    input  logic [VEC_W-1:0]  msi_vec,
    input  logic [PLD_W-1:0]  msi_data,
    input  logic [N_INTX-1:0] intx_assert,
    input  logic [N_INTX-1:0] intx_deassert,
    input  logic              pme_evt,
    input  logic              pwr_chg_evt,
    input  logic              flush_evt,
    output logic              irq_o
);
    logic [DATA_W-1:0] l1_q, l2_q, host_q;
    logic [DATA_W-1:0] l1_set, l2_set, host_set;
    logic [DATA_W-1:0] l1_mask, l2_mask, host_mask;
    logic [DATA_W-1:0] addr_lo, addr_hi;
    logic [N_VECS-1:0] msi_q, msi_mask;
    logic [PLD_W-1:0]  payload;
    logic              msi_act, l1_act, l2_act, host_act;

    function automatic logic wsel(input logic [ADDR_W-1:0] a, input reg_addr_e r);
        return bus_we && (a == r);
    endfunction

    irqagg_msi_bank #(.VECS(N_VECS), .VEC_W(VEC_W), .PAYLOAD_W(PLD_W)) u_msi (
        .clk(clk), .rst_n(rst_n),
        .msi_valid(msi_valid), .msi_vec(msi_vec), .msi_data(msi_data),
        .stat_we(wsel(bus_addr, A_MSI_STAT)), .mask_we(wsel(bus_addr, A_MSI_MASK)),
        .wdata(bus_wdata[N_VECS-1:0]),
        .stat_q(msi_q), .mask_q(msi_mask), .payload_q(payload), .active(msi_act)
    );

    always_comb begin
        l1_set = '0;
        l2_set = '0;
        host_set = '0;
        l1_set[L1_MSI_BIT]   = msi_act;
        l1_set[L1_PME_BIT]   = pme_evt;
        l2_set[L2_PWR_BIT]   = pwr_chg_evt;
        l2_set[L2_FLUSH_BIT] = flush_evt;
        for (int n = 0; n < N_INTX; n++) begin
            l1_set[L1_ASRT_BASE+n] = intx_assert[n];
            l1_set[L1_DEAS_BASE+n] = intx_deassert[n];
            l2_set[L2_ASRT_BASE+n] = intx_assert[n];
        end
        host_set[HOST_CORE] = l1_act | l2_act;
    end

    irqagg_w1c_reg #(.W(DATA_W), .VALID(L1_VALID)) u_l1 (
        .clk(clk), .rst_n(rst_n), .set_i(l1_set),
        .clr_we(wsel(bus_addr, A_L1_STAT)), .clr_i(bus_wdata), .q(l1_q)
    );
    irqagg_w1c_reg #(.W(DATA_W), .VALID(L2_VALID)) u_l2 (
        .clk(clk), .rst_n(rst_n), .set_i(l2_set),
        .clr_we(wsel(bus_addr, A_L2_STAT)), .clr_i(bus_wdata), .q(l2_q)
    );
    irqagg_w1c_reg #(.W(DATA_W), .VALID(HOST_IMPL)) u_host (
        .clk(clk), .rst_n(rst_n), .set_i(host_set),
        .clr_we(wsel(bus_addr, A_HOST_STAT)), .clr_i(bus_wdata), .q(host_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l1_mask   <= L1_VALID;
            l2_mask   <= L2_VALID;
            host_mask <= HOST_IMPL;
            addr_lo   <= '0;
            addr_hi   <= '0;
        end else begin
            if (wsel(bus_addr, A_L1_MASK))     l1_mask   <= bus_wdata & L1_VALID;
            if (wsel(bus_addr, A_L2_MASK))     l2_mask   <= bus_wdata & L2_VALID;
            if (wsel(bus_addr, A_HOST_MASK))   host_mask <= bus_wdata & HOST_IMPL;
            if (wsel(bus_addr, A_MSI_ADDR_LO)) addr_lo   <= bus_wdata;
            if (wsel(bus_addr, A_MSI_ADDR_HI)) addr_hi   <= bus_wdata;
        end
    end

    always_comb begin
        l1_act   = |(l1_q & ~l1_mask & L1_VALID);
        l2_act   = |(l2_q & ~l2_mask & L2_VALID);
        host_act = |(host_q & ~host_mask & HOST_IMPL);
    end

    irqagg_irq_fsm u_fsm (.clk(clk), .rst_n(rst_n), .core_act(host_act), .irq_o(irq_o));

    always_comb begin
        unique case (bus_addr)
            A_L1_STAT:     bus_rdata = l1_q;
            A_L1_MASK:     bus_rdata = l1_mask;
            A_L2_STAT:     bus_rdata = l2_q;
            A_L2_MASK:     bus_rdata = l2_mask;
            A_HOST_STAT:   bus_rdata = host_q;
            A_HOST_MASK:   bus_rdata = host_mask;
            A_MSI_STAT:    bus_rdata = DATA_W'(msi_q);
            A_MSI_MASK:    bus_rdata = DATA_W'(msi_mask);
            A_MSI_DATA:    bus_rdata = DATA_W'(payload);
            A_MSI_ADDR_LO: bus_rdata = addr_lo;
            A_MSI_ADDR_HI: bus_rdata = addr_hi;
            default:       bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/irqagg_chk.sv
module irqagg_chk #(
    parameter int N_VECS = 32,
    parameter int VEC_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              msi_valid,
    input logic [VEC_W-1:0]  msi_vec,
    input logic [N_VECS-1:0] msi_q,
    input logic              msi_act,
    input logic [31:0]       l1_q,
    input logic              l1_act,
    input logic              l2_act,
    input logic [31:0]       host_q,
    input logic              host_act,
    input logic              intx0,
    input logic              irq_o
);
    AST_MSI_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        msi_valid |=> msi_q[$past(msi_vec)]); // R2
    AST_MSI_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
        msi_act |=> l1_q[24]); // R3
    AST_CORE_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (l1_act || l2_act) |=> host_q[16]); // R5
    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        host_act |=> irq_o); // R6
    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        !host_act |=> !irq_o); // R6
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        intx0 |=> l1_q[16]); // R8
endmodule

bind irqagg_top irqagg_chk #(.N_VECS(N_VECS), .VEC_W(VEC_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_vec(msi_vec),
    .msi_q(msi_q), .msi_act(msi_act), .l1_q(l1_q), .l1_act(l1_act),
    .l2_act(l2_act), .host_q(host_q), .host_act(host_act),
    .intx0(intx_assert[0]), .irq_o(irq_o)
);

// File: tb/irqagg_top_tb.sv
module irqagg_top_tb;
    import irqagg_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef enum logic [3:0] {
        OP_WR, OP_RD, OP_IRQ, OP_MSI, OP_ASRT, OP_DEAS, OP_PME, OP_PWR, OP_FLUSH, OP_IDLE
    } op_e;

    typedef struct packed {
        op_e         op;
        logic [3:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 53;
    localparam vec_t TBL [NV] = '{
        '{OP_WR,   4'd5,  32'h0,          4'd9},  // unmask host
        '{OP_RD,   4'd5,  32'h0,          4'd9},  // R9
        '{OP_WR,   4'd3,  32'h0,          4'd9},
        '{OP_WR,   4'd1,  32'h0,          4'd9},
        '{OP_WR,   4'd7,  32'hFFFF_FFFE,  4'd9},  // only vector 0 unmasked
        '{OP_MSI,  4'd0,  32'h0000_095A,  4'd2},  // vec 9 masked
        '{OP_IDLE, 4'd0,  32'd4,          4'd2},
        '{OP_RD,   4'd6,  32'h0000_0200,  4'd2},  // R2
        '{OP_RD,   4'd8,  32'h0000_005A,  4'd2},  // R2
        '{OP_RD,   4'd0,  32'h0,          4'd3},  // R3 masked vector
        '{OP_IRQ,  4'd0,  32'd0,          4'd6},
        '{OP_MSI,  4'd0,  32'h0000_00A5,  4'd2},  // vec 0 unmasked
        '{OP_IDLE, 4'd0,  32'd4,          4'd3},
        '{OP_RD,   4'd0,  32'h0100_0000,  4'd3},  // R3
        '{OP_RD,   4'd4,  32'h0001_0000,  4'd5},  // R5
        '{OP_IRQ,  4'd0,  32'd1,          4'd6},  // R6
        '{OP_RD,   4'd8,  32'h0000_00A5,  4'd2},
        '{OP_WR,   4'd6,  32'hFFFF_FFFF,  4'd7},  // R7 clear all
        '{OP_WR,   4'd0,  32'h0100_0000,  4'd7},
        '{OP_WR,   4'd4,  32'h0001_0000,  4'd7},
        '{OP_IDLE, 4'd0,  32'd2,          4'd7},
        '{OP_RD,   4'd6,  32'h0,          4'd7},
        '{OP_RD,   4'd0,  32'h0,          4'd7},
        '{OP_RD,   4'd4,  32'h0,          4'd7},
        '{OP_IRQ,  4'd0,  32'd0,          4'd6},
        '{OP_ASRT, 4'd0,  32'd2,          4'd4},
        '{OP_IDLE, 4'd0,  32'd3,          4'd4},
        '{OP_RD,   4'd0,  32'h0004_0000,  4'd4},  // R4
        '{OP_RD,   4'd2,  32'h0000_0400,  4'd4},
        '{OP_IRQ,  4'd0,  32'd1,          4'd6},
        '{OP_DEAS, 4'd0,  32'd2,          4'd4},
        '{OP_PME,  4'd0,  32'd0,          4'd4},
        '{OP_IDLE, 4'd0,  32'd1,          4'd4},
        '{OP_RD,   4'd0,  32'h0044_0080,  4'd4},
        '{OP_WR,   4'd1,  32'h07FF_FFFF,  4'd5},  // mask both levels
        '{OP_WR,   4'd3,  32'h0000_0FF0,  4'd5},
        '{OP_WR,   4'd4,  32'hFFFF_FFFF,  4'd5},
        '{OP_IDLE, 4'd0,  32'd2,          4'd5},
        '{OP_RD,   4'd4,  32'h0,          4'd5},  // R5 masked levels
        '{OP_IRQ,  4'd0,  32'd0,          4'd6},
        '{OP_RD,   4'd0,  32'h0044_0080,  4'd3},  // R3 mask keeps status
        '{OP_WR,   4'd1,  32'h0,          4'd6},
        '{OP_IDLE, 4'd0,  32'd3,          4'd6},
        '{OP_IRQ,  4'd0,  32'd1,          4'd6},
        '{OP_WR,   4'd5,  32'h0001_0000,  4'd6},  // host mask core bit
        '{OP_IDLE, 4'd0,  32'd2,          4'd6},
        '{OP_IRQ,  4'd0,  32'd0,          4'd6},  // R6
        '{OP_RD,   4'd4,  32'h0001_0000,  4'd6},
        '{OP_WR,   4'd0,  32'h0004_0000,  4'd7},  // R7 partial clear
        '{OP_IDLE, 4'd0,  32'd1,          4'd7},
        '{OP_RD,   4'd0,  32'h0040_0080,  4'd7},
        '{OP_PWR,  4'd0,  32'd0,          4'd4},
        '{OP_FLUSH,4'd0,  32'd0,          4'd4}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        msi_valid = 1'b0;
    logic [4:0]  msi_vec = '0;
    logic [7:0]  msi_data = '0;
    logic [3:0]  intx_assert = '0;
    logic [3:0]  intx_deassert = '0;
    logic        pme_evt = 1'b0;
    logic        pwr_chg_evt = 1'b0;
    logic        flush_evt = 1'b0;
    logic        irq_o;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irqagg_top u_dut (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .msi_valid(msi_valid),
        .msi_vec(msi_vec), .msi_data(msi_data), .intx_assert(intx_assert),
        .intx_deassert(intx_deassert), .pme_evt(pme_evt), .pwr_chg_evt(pwr_chg_evt),
        .flush_evt(flush_evt), .irq_o(irq_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic quiet();
        bus_we = 1'b0; msi_valid = 1'b0; intx_assert = '0; intx_deassert = '0;
        pme_evt = 1'b0; pwr_chg_evt = 1'b0; flush_evt = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string req);
        @(negedge clk); quiet(); bus_addr = a; #1;
        check(req, bus_rdata, exp);
    endtask

    task automatic run_op(input vec_t v);
        string tag;
        tag = $sformatf("R%0d", v.req);
        @(negedge clk);
        quiet();
        unique case (v.op)
            OP_WR:    begin bus_we = 1'b1; bus_addr = v.addr; bus_wdata = v.data; end
            OP_RD:    begin bus_addr = v.addr; #1; check(tag, bus_rdata, v.data); end
            OP_IRQ:   check(tag, {31'd0, irq_o}, v.data);
            OP_MSI:   begin msi_valid = 1'b1; msi_vec = v.data[12:8]; msi_data = v.data[7:0]; end
            OP_ASRT:  intx_assert[v.data[1:0]] = 1'b1;
            OP_DEAS:  intx_deassert[v.data[1:0]] = 1'b1;
            OP_PME:   pme_evt = 1'b1;
            OP_PWR:   pwr_chg_evt = 1'b1;
            OP_FLUSH: flush_evt = 1'b1;
            OP_IDLE:  repeat (v.data) @(posedge clk);
            default:  ;
        endcase
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", {31'd0, irq_o}, 32'd0);
        rd(4'd0, 32'h0, "R1");
        rd(4'd1, 32'h07FF_FFFF, "R1");
        rd(4'd3, 32'h0000_0FF0, "R1");
        rd(4'd5, 32'h00FF_F0FB, "R1");
        rd(4'd7, 32'hFFFF_FFFF, "R1");
        rd(4'd8, 32'h0, "R1");
        rd(4'd9, 32'h0, "R1");

        for (int i = 0; i < NV; i++) run_op(TBL[i]);

        rd(4'd2, 32'h0000_0430, "R4 power and flush");

        // R8: event and clear in the same cycle
        @(negedge clk); quiet();
        intx_assert[1] = 1'b1; bus_we = 1'b1; bus_addr = 4'd0; bus_wdata = 32'h0002_0000;
        rd(4'd0, 32'h0042_0080, "R8 intx");
        @(negedge clk); quiet();
        msi_valid = 1'b1; msi_vec = 5'd3; msi_data = 8'h33;
        bus_we = 1'b1; bus_addr = 4'd6; bus_wdata = 32'h0000_0008;
        rd(4'd6, 32'h0000_0008, "R8 msi");

        // R9 readback and masking of writes
        @(negedge clk); quiet(); bus_we = 1'b1; bus_addr = 4'd9; bus_wdata = 32'hDEAD_BEEF;
        rd(4'd9, 32'hDEAD_BEEF, "R9");
        @(negedge clk); quiet(); bus_we = 1'b1; bus_addr = 4'd10; bus_wdata = 32'h1234_5678;
        rd(4'd10, 32'h1234_5678, "R9");
        @(negedge clk); quiet(); bus_we = 1'b1; bus_addr = 4'd3; bus_wdata = 32'hFFFF_FFFF;
        rd(4'd3, 32'h0000_0FF0, "R9");
        @(negedge clk); quiet(); bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = 32'hFFFF_FFFF;
        rd(4'd5, 32'h00FF_F0FB, "R9");
        @(negedge clk); quiet(); bus_we = 1'b1; bus_addr = 4'd8; bus_wdata = 32'h0;
        rd(4'd8, 32'h0000_0033, "R9 payload read-only");
        rd(4'd12, 32'h0, "R10 unmapped");

        // R1 reset mid-run
        @(negedge clk); quiet(); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid-run", {31'd0, irq_o}, 32'd0);
        rd(4'd0, 32'h0, "R1 mid-run");
        rd(4'd10, 32'h0, "R1 mid-run");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule